// File: doc/BRIEF.md
# Reference/Feedback Lock Supervisor

This block watches a PLL from the digital side. It receives the reference clock and the divided VCO feedback clock as sampled levels. Each level passes through a two-flop synchronizer, and the block then takes its rising edges as single-cycle enables. It counts feedback edges across a measurement window that the reference edges time. At the end of each window it decides whether the two frequencies agree within a tolerance band. Small deviations inside the band are deliberately accepted. Lock is only declared after a run of good windows.

When a window fails while the loop is locked, that is a loss-of-lock event. The lock status drops at once. A sticky trap flag is raised if the trap is enabled, and a disconnect control goes high so that downstream logic can cut its clock away from the VCO. The disconnect stays asserted until lock is declared again after a detection restart. Software-side logic pulses the detection restart after it reprograms the dividers, so that the check time is defined from that point.

Top module: `vco_lock_mon`

## Requirements
- R1: After reset, `locked_o`, `trap_o` and `clk_disc_o` are all 0.
- R2: A window spans WIN (default 256) rising edges of the synchronized reference input. `locked_o` rises after LOCK_WINS (default 4) consecutive windows in which the feedback rising-edge count differs from WIN by at most TOL (default 2).
- R3: After a detection restart, `locked_o` stays 0 while fewer than LOCK_WINS good windows have completed.
- R4: A count difference of exactly TOL in either direction counts as a good window. A difference of TOL+1 is a bad window and never leads to lock.
- R5: A bad window clears `locked_o` at the end of that window and restarts the good-window run from zero.
- R6: A bad window while locked is a loss event. It sets `trap_o` only if `trap_en_i` is 1 in that cycle.
- R7: A loss event sets `clk_disc_o` to 1.
- R8: `clk_disc_o` stays 1 after a loss event, even if lock returns. It clears only when lock is declared after a `det_reset_i` pulse issued since the loss.
- R9: `trap_o` stays 1 until `trap_clr_i` is sampled high. If a clear and a new trap-enabled loss event fall in the same cycle, `trap_o` stays 1.
- R10: `det_reset_i` clears `locked_o` in the next cycle and restarts the window and the good-window run. It is not a loss event: it changes neither `trap_o` nor `clk_disc_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_clk_i | input | 1 | Sampled reference clock level |
| fb_clk_i | input | 1 | Sampled divided-feedback clock level |
| det_reset_i | input | 1 | Single-cycle restart of lock detection |
| trap_en_i | input | 1 | Enables trap raising on loss of lock |
| trap_clr_i | input | 1 | Clears the sticky trap flag |
| locked_o | output | 1 | Lock status |
| trap_o | output | 1 | Sticky loss-of-lock trap flag |
| clk_disc_o | output | 1 | Request to disconnect downstream clock from the VCO |

## Verification
The assertions assume three things about the inputs. Each clock input holds every level for at least one system-clock cycle, so that consecutive edges on one input are at least two cycles apart. The restart and clear inputs are synchronous to `clk_i`. The trap enable is stable around the sampling edge. The bench changes every input on the falling edge. It toggles the reference every two cycles. It builds the feedback from a 16-bit phase accumulator whose step gives exactly WIN plus a chosen offset of edges per window, with periods close to four cycles. Every edge therefore survives the synchronizer, and each full window sees a known count.

// File: rtl/vlm_pkg.sv
package vlm_pkg;
  typedef struct packed {
    logic done;
    logic ok;
  } win_res_t;
endpackage

// File: rtl/vlm_edge_sync.sv
module vlm_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  // pipe[STAGES-1] is the synchronized level, pipe[STAGES] its history
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-1:0], lvl_i};
  end

  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];

  p_rise_spaced_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/vlm_win_cnt.sv
module vlm_win_cnt
  import vlm_pkg::*;
#(
  parameter int unsigned WIN = 256,
  parameter int unsigned TOL = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     restart_i,
  input  logic     ref_rise_i,
  input  logic     fb_rise_i,
  output win_res_t res_o
);
  localparam int unsigned REF_W  = (WIN > 1) ? $clog2(WIN) : 1;
  localparam int unsigned CNT_W  = $clog2(WIN) + 2;
  localparam logic [CNT_W-1:0] FB_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LO_LIM = CNT_W'(WIN - TOL);
  localparam logic [CNT_W-1:0] HI_LIM = CNT_W'(WIN + TOL);

  logic [REF_W-1:0] ref_cnt_q;
  logic [CNT_W-1:0] fb_cnt_q, fb_nxt;
  logic             last_edge, in_band;
  win_res_t         res_q;

  assign fb_nxt    = fb_cnt_q + CNT_W'(fb_rise_i && (fb_cnt_q != FB_MAX));
  assign last_edge = ref_rise_i && (ref_cnt_q == REF_W'(WIN - 1));
  assign in_band   = (fb_nxt >= LO_LIM) && (fb_nxt <= HI_LIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_cnt_q <= '0;
      fb_cnt_q  <= '0;
      res_q     <= '0;
    end else if (restart_i) begin
      ref_cnt_q <= '0;
      fb_cnt_q  <= '0;
      res_q     <= '0;
    end else begin
      res_q.done <= last_edge;
      res_q.ok   <= last_edge && in_band;
      if (last_edge) begin
        ref_cnt_q <= '0;
        fb_cnt_q  <= '0;
      end else begin
        ref_cnt_q <= ref_cnt_q + REF_W'(ref_rise_i);
        fb_cnt_q  <= fb_nxt;
      end
    end
  end

  assign res_o = res_q;

  p_restart_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !res_q.done);
  p_ok_only_at_end_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_q.ok |-> res_q.done);
  p_done_spaced_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_q.done |=> !res_q.done);
endmodule

// File: rtl/vlm_lock_fsm.sv
module vlm_lock_fsm
  import vlm_pkg::*;
#(
  parameter int unsigned LOCK_WINS = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  win_res_t res_i,
  input  logic     det_reset_i,
  input  logic     trap_en_i,
  input  logic     trap_clr_i,
  output logic     locked_o,
  output logic     trap_o,
  output logic     disc_o
);
  localparam int unsigned GW = $clog2(LOCK_WINS + 1);

  logic [GW-1:0] good_q, good_nxt;
  logic          locked_q, rearm_q, disc_q, trap_q;
  logic          loss_evt;

  assign good_nxt = (good_q == GW'(LOCK_WINS)) ? good_q : good_q + 1'b1;
  assign loss_evt = res_i.done && !res_i.ok && locked_q && !det_reset_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      good_q   <= '0;
      locked_q <= 1'b0;
      rearm_q  <= 1'b1;
      disc_q   <= 1'b0;
    end else if (det_reset_i) begin
      good_q   <= '0;
      locked_q <= 1'b0;
      rearm_q  <= 1'b1;
    end else if (res_i.done) begin
      if (res_i.ok) begin
        good_q <= good_nxt;
        if (good_nxt == GW'(LOCK_WINS)) begin
          locked_q <= 1'b1;
          if (rearm_q) disc_q <= 1'b0;
        end
      end else begin
        good_q   <= '0;
        locked_q <= 1'b0;
        if (locked_q) begin
          disc_q  <= 1'b1;
          rearm_q <= 1'b0;
        end
      end
    end
  end

  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trap_q <= 1'b0;
    else         trap_q <= (loss_evt && trap_en_i) || (trap_q && !trap_clr_i);
  end

  assign locked_o = locked_q;
  assign trap_o   = trap_q;
  assign disc_o   = disc_q;

  p_trap_gated_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trap_q) |-> $past(trap_en_i));
  p_lock_drop_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_q) |-> $past(det_reset_i || (res_i.done && !res_i.ok)));
  p_lock_needs_good_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_q) |-> $past(res_i.done && res_i.ok));
  p_disc_on_loss_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loss_evt |=> disc_q);
  p_set_beats_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loss_evt && trap_en_i) |=> trap_q);
  p_disc_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(disc_q) |-> locked_q);
endmodule

// File: rtl/vco_lock_mon.sv
module vco_lock_mon
  import vlm_pkg::*;
#(
  parameter int unsigned WIN       = 256,
  parameter int unsigned TOL       = 2,
  parameter int unsigned LOCK_WINS = 4,
  parameter int unsigned SYNC_STG  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_clk_i,
  input  logic fb_clk_i,
  input  logic det_reset_i,
  input  logic trap_en_i,
  input  logic trap_clr_i,
  output logic locked_o,
  output logic trap_o,
  output logic clk_disc_o
);
  localparam int unsigned NCH = 2; // 0: reference, 1: feedback

  logic [NCH-1:0] lvl, rise;
  win_res_t       win_res;

  assign lvl = {fb_clk_i, ref_clk_i};

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    vlm_edge_sync #(.STAGES(SYNC_STG)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .lvl_i  (lvl[c]),
      .rise_o (rise[c])
    );
  end

  vlm_win_cnt #(.WIN(WIN), .TOL(TOL)) u_win (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .restart_i  (det_reset_i),
    .ref_rise_i (rise[0]),
    .fb_rise_i  (rise[1]),
    .res_o      (win_res)
  );

  vlm_lock_fsm #(.LOCK_WINS(LOCK_WINS)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .res_i       (win_res),
    .det_reset_i (det_reset_i),
    .trap_en_i   (trap_en_i),
    .trap_clr_i  (trap_clr_i),
    .locked_o    (locked_o),
    .trap_o      (trap_o),
    .disc_o      (clk_disc_o)
  );

  p_restart_drops_lock_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_reset_i |=> !locked_o);
endmodule

// File: tb/vco_lock_mon_bench.sv
module vco_lock_mon_bench;
  localparam int W = 1024; // cycles per window: 256 ref edges, period 4

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_clk = 1'b0, fb_clk;
  logic det_reset = 1'b0, trap_en = 1'b0, trap_clr = 1'b0;
  logic locked, trap, disc;
  logic ref_div = 1'b0;
  logic [15:0] acc = '0;
  int fb_delta = 0;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  vco_lock_mon u_vco_lock_mon (
    .clk_i(clk), .rst_ni(rst_n), .ref_clk_i(ref_clk), .fb_clk_i(fb_clk),
    .det_reset_i(det_reset), .trap_en_i(trap_en), .trap_clr_i(trap_clr),
    .locked_o(locked), .trap_o(trap), .clk_disc_o(disc)
  );

  // feedback edges per 1024 cycles = 256 + fb_delta exactly
  always @(negedge clk) begin
    ref_div <= ~ref_div;
    if (ref_div) ref_clk <= ~ref_clk;
    acc <= acc + 16'(64 * (256 + fb_delta));
  end
  assign fb_clk = acc[15];

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_det();
    @(negedge clk); det_reset = 1'b1;
    @(negedge clk); det_reset = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; wait_cyc(4);
    rst_n = 1'b1; wait_cyc(2);
    check("R1 locked", locked, 1'b0);
    check("R1 trap", trap, 1'b0);
    check("R1 disc", disc, 1'b0);
  endtask

  task automatic t_lock_streak();
    fb_delta = 0;
    pulse_det();
    wait_cyc(3 * W + 512);
    check("R3 early lock", locked, 1'b0);
    wait_cyc(W / 2 + 300);
    check("R2 lock after streak", locked, 1'b1);
    check("R2 no disc", disc, 1'b0);
  endtask

  task automatic t_tol_edge();
    fb_delta = 2; pulse_det(); wait_cyc(6 * W);
    check("R4 plus tol", locked, 1'b1);
    fb_delta = -2; pulse_det(); wait_cyc(6 * W);
    check("R4 minus tol", locked, 1'b1);
  endtask

  task automatic t_loss_no_trap();
    trap_en = 1'b0;
    fb_delta = 3; wait_cyc(2 * W + 50);
    check("R5 lock cleared", locked, 1'b0);
    check("R7 disc on loss", disc, 1'b1);
    check("R6 trap gated off", trap, 1'b0);
    wait_cyc(6 * W);
    check("R4 over tol no lock", locked, 1'b0);
  endtask

  task automatic t_disc_hold();
    fb_delta = 0; wait_cyc(6 * W);
    check("R8 relock", locked, 1'b1);
    check("R8 disc held", disc, 1'b1);
    pulse_det(); wait_cyc(2);
    check("R10 restart drops lock", locked, 1'b0);
    wait_cyc(6 * W);
    check("R8 relock after restart", locked, 1'b1);
    check("R8 disc released", disc, 1'b0);
  endtask

  task automatic t_trap_sticky();
    trap_en = 1'b1;
    fb_delta = 20; wait_cyc(2 * W + 50);
    check("R6 trap set", trap, 1'b1);
    check("R5 unlocked", locked, 1'b0);
    fb_delta = 0; pulse_det(); wait_cyc(6 * W);
    check("R9 relocked", locked, 1'b1);
    check("R9 trap sticky", trap, 1'b1);
    @(negedge clk); trap_clr = 1'b1;
    @(negedge clk); trap_clr = 1'b0;
    wait_cyc(1);
    check("R9 trap cleared", trap, 1'b0);
  endtask

  task automatic t_det_not_loss();
    trap_en = 1'b1;
    pulse_det(); wait_cyc(3);
    check("R10 locked", locked, 1'b0);
    check("R10 trap", trap, 1'b0);
    check("R10 disc", disc, 1'b0);
    wait_cyc(6 * W);
    check("R10 relock", locked, 1'b1);
  endtask

  task automatic t_clr_collision();
    trap_en = 1'b1;
    @(negedge clk); trap_clr = 1'b1;
    fb_delta = -20;
    for (int i = 0; i < 3 * W && locked; i++) @(negedge clk);
    check("R9 set beats clear", trap, 1'b1);
    @(negedge clk);
    check("R9 clear after", trap, 1'b0);
    trap_clr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_lock_streak();
    t_tol_edge();
    t_loss_no_trap();
    t_disc_hold();
    t_trap_sticky();
    t_det_not_loss();
    t_clr_collision();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule